// File: doc/BRIEF.md
# Telephony Codec Control and Powerdown Core

This block is the digital control core of a PCM voice codec. Two 8-bit control registers are filled serially from a control-stream input. Bits are taken on falling edges of the bit clock while the active-low frame strobe is low. Register A holds a six-bit gain field and a two-bit sleep request. Register B drives six general-purpose logic outputs and a two-bit test-mode select.

The core merges four sources into one powerdown flag. In priority order they are: a start-up window after reset, a bit clock that has stopped high, a sleep request written into register A, and a forced condition in which the mode-select input is high while the control input stays high. The data-output enable is the inverse of that flag.

Everything runs on one free-running reference clock. The bit clock, frame strobe, control input and mode select are oversampled through a synchronizer. The clock-loss timer counts reference cycles since the last bit-clock falling edge.

Top module: `pcmctl_core`

## Requirements
- R1: After reset is released, `pwrdn_o` stays high until PWRUP_EDGES (default 25) bit-clock falling edges have been counted. Frames sent in that window change no register.
- R2: While the start-up window or clock loss is active, register A is forced to 0xC0 (gain 0, sleep bits 11) and register B to 0x00. So `sd_o`, `test_sel_o` and `gain_o` read zero.
- R3: When no bit-clock falling edge has been seen for LOSS_LIMIT reference cycles, clock loss is raised. LOSS_LIMIT must lie in the 10 to 40 µs range. Loss ends at the next falling edge, and that edge loads no bit. The registers keep their forced values until they are reloaded.
- R4: While the frame strobe is low, each falling edge takes one bit, most significant bit first by default. Register A is written after the 8th bit and register B after the 16th. Further bits in the same frame are ignored. A high strobe restarts the bit count at zero.
- R5: When register A bits 7 and 6 are both 1, `pwrdn_o` is 1.
- R6: During a register-A sleep request, `sd_o` keeps its value and still follows new register-B loads.
- R7: When `mode_neg` is high and `ctl_in` is 1 on FORCE_BITS consecutive falling edges, `pwrdn_o` goes high with no register change. It drops once `mode_neg` is low or a falling edge samples `ctl_in` as 0.
- R8: `sd_o` equals register B bits 5..0. `test_sel_o` equals register B bits 7..6, encoded as 00 normal, 01 transmit-filter test, 10 receive-filter test, 11 codec test.
- R9: `dout_en_o` is always the inverse of `pwrdn_o`.
- R10: `gain_o` equals register A bits 5..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| bclk | input | 1 | Bit clock, oversampled |
| frame_n | input | 1 | Active-low frame strobe enabling serial loads |
| ctl_in | input | 1 | Serial control stream |
| mode_neg | input | 1 | Mode select, high enables the forced-powerdown detector |
| pwrdn_o | output | 1 | Combined powerdown flag |
| dout_en_o | output | 1 | Data-output enable (tri-state control) |
| sd_o | output | 6 | Logic outputs from register B |
| test_sel_o | output | 2 | Test-mode select from register B |
| gain_o | output | 6 | Gain field from register A |

## Verification
The bench builds the core with three synchronizer stages rather than two, so the reference model's latency is checked at a depth other than the default. FORCE_BITS is set to 4 so the forced-powerdown threshold is reached in a few bits. The start-up length stays at 25, and LOSS_LIMIT keeps its 20 µs default at the 125 MHz reference. Stopping the bit clock for about 21 µs therefore reaches the real loss threshold and then the recovery edge.

// File: rtl/pcmctl_pkg.sv
package pcmctl_pkg;

   localparam int unsigned REG_W  = 8;
   localparam int unsigned GAIN_W = 6;
   localparam int unsigned SD_W   = 6;
   localparam int unsigned TSEL_W = REG_W - SD_W;

   localparam logic [REG_W-1:0] REG_A_FORCED = 8'hC0;
   localparam logic [REG_W-1:0] REG_B_FORCED = 8'h00;

   typedef enum logic [TSEL_W-1:0] {
      TM_NORMAL  = 2'b00,
      TM_TX_FILT = 2'b01,
      TM_RX_FILT = 2'b10,
      TM_CODEC   = 2'b11
   } test_mode_e;

   function automatic logic sleep_req(input logic [REG_W-1:0] a);
      return a[REG_W-1] & a[REG_W-2];
   endfunction

endpackage

// File: rtl/pcmctl_sync.sv
module pcmctl_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcmctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
         prev_q <= 1'b0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
         prev_q <= stg[STAGES-1][0];
      end
   end

   assign q_o    = stg[STAGES-1];
   assign fall_o = prev_q & ~stg[STAGES-1][0];

endmodule

// File: rtl/pcmctl_pwrup.sv
module pcmctl_pwrup #(
   parameter int unsigned EDGES = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   output logic active_o
);

   localparam int unsigned CW = $clog2(EDGES + 1);
   localparam logic [CW-1:0] DONE = CW'(EDGES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (active_o && fall_i) cnt_q <= cnt_q + 1'b1;
   end

   assign active_o = (cnt_q != DONE);

   // R1: once the window has closed it never reopens
   a_r1_window_once: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |=> !active_o);

endmodule

// File: rtl/pcmctl_loss.sv
module pcmctl_loss #(
   parameter int unsigned LIMIT = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   output logic loss_o
);

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fall_i)       cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign loss_o = (cnt_q == TOP);

   // R3: a falling edge always ends clock loss
   a_r3_edge_clears_loss: assert property (@(posedge clk) disable iff (!rst_n)
      fall_i |=> !loss_o);

endmodule

// File: rtl/pcmctl_force.sv
module pcmctl_force #(
   parameter int unsigned BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hard_i,
   input  logic fall_i,
   input  logic mode_i,
   input  logic ctl_i,
   output logic force_o
);

   localparam int unsigned CW = $clog2(BITS + 1);
   localparam logic [CW-1:0] TOP = CW'(BITS);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (hard_i || !mode_i) run_q <= '0;
      else if (fall_i) begin
         if (!ctl_i)              run_q <= '0;
         else if (run_q != TOP)   run_q <= run_q + 1'b1;
      end
   end

   assign force_o = (run_q == TOP);

   // R7: dropping the mode select ends the forced state
   a_r7_mode_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i |=> !force_o);

endmodule

// File: rtl/pcmctl_loader.sv
module pcmctl_loader
   import pcmctl_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hard_i,
   input  logic             frame_hi_i,
   input  logic             fall_i,
   input  logic             bit_i,
   output logic [REG_W-1:0] reg_a_o,
   output logic [REG_W-1:0] reg_b_o
);

   localparam int unsigned NBITS = 2 * REG_W;
   localparam int unsigned CW    = $clog2(NBITS + 1);
   localparam logic [CW-1:0] END_A = CW'(REG_W - 1);
   localparam logic [CW-1:0] END_B = CW'(NBITS - 1);
   localparam logic [CW-1:0] FULL  = CW'(NBITS);

   logic [CW-1:0]    bit_cnt_q;
   logic [REG_W-1:0] shift_q, shift_nxt;

   if (MSB_FIRST) begin : g_msb
      assign shift_nxt = {shift_q[REG_W-2:0], bit_i};
   end else begin : g_lsb
      assign shift_nxt = {bit_i, shift_q[REG_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         shift_q   <= '0;
         reg_a_o   <= REG_A_FORCED;
         reg_b_o   <= REG_B_FORCED;
      end else if (hard_i) begin
         bit_cnt_q <= '0;
         shift_q   <= '0;
         reg_a_o   <= REG_A_FORCED;
         reg_b_o   <= REG_B_FORCED;
      end else if (frame_hi_i) begin
         bit_cnt_q <= '0;
      end else if (fall_i && (bit_cnt_q != FULL)) begin
         shift_q   <= shift_nxt;
         bit_cnt_q <= bit_cnt_q + 1'b1;
         if (bit_cnt_q == END_A) reg_a_o <= shift_nxt;
         if (bit_cnt_q == END_B) reg_b_o <= shift_nxt;
      end
   end

   // R4: a high frame strobe restarts the bit count
   a_r4_frame_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      frame_hi_i |=> (bit_cnt_q == '0));

   // R4: registers change only on a counted falling edge or a forced state
   a_r4_load_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!hard_i && !fall_i) |=> ($stable(reg_a_o) && $stable(reg_b_o)));

endmodule

// File: rtl/pcmctl_core.sv
module pcmctl_core
   import pcmctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PWRUP_EDGES = 25,
   parameter int unsigned REF_CLK_KHZ = 125000,
   parameter int unsigned LOSS_LIMIT  = 2500,
   parameter int unsigned FORCE_BITS  = 16,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              frame_n,
   input  logic              ctl_in,
   input  logic              mode_neg,
   output logic              pwrdn_o,
   output logic              dout_en_o,
   output logic [SD_W-1:0]   sd_o,
   output logic [TSEL_W-1:0] test_sel_o,
   output logic [GAIN_W-1:0] gain_o
);

   localparam longint unsigned LOSS_MIN = (64'd10 * REF_CLK_KHZ) / 1000;
   localparam longint unsigned LOSS_MAX = (64'd40 * REF_CLK_KHZ) / 1000;

   if (LOSS_LIMIT < LOSS_MIN || LOSS_LIMIT > LOSS_MAX) begin : g_bad_loss
      $error("pcmctl_core: LOSS_LIMIT outside the 10..40 us window");
   end
   if (PWRUP_EDGES == 0) begin : g_bad_pwrup
      $error("pcmctl_core: PWRUP_EDGES must be nonzero");
   end
   if (FORCE_BITS == 0) begin : g_bad_force
      $error("pcmctl_core: FORCE_BITS must be nonzero");
   end

   logic [3:0]       in_s;
   logic             fall;
   logic             pwr_act, loss, forced, hard, sw_req;
   logic [REG_W-1:0] reg_a, reg_b;

   pcmctl_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk(clk_ref), .rst_n(rst_n),
      .d_i({mode_neg, ctl_in, frame_n, bclk}),
      .q_o(in_s), .fall_o(fall)
   );

   pcmctl_pwrup #(.EDGES(PWRUP_EDGES)) u_pwrup (
      .clk(clk_ref), .rst_n(rst_n), .fall_i(fall), .active_o(pwr_act)
   );

   pcmctl_loss #(.LIMIT(LOSS_LIMIT)) u_loss (
      .clk(clk_ref), .rst_n(rst_n), .fall_i(fall), .loss_o(loss)
   );

   assign hard = pwr_act | loss;

   pcmctl_force #(.BITS(FORCE_BITS)) u_force (
      .clk(clk_ref), .rst_n(rst_n), .hard_i(hard), .fall_i(fall),
      .mode_i(in_s[3]), .ctl_i(in_s[2]), .force_o(forced)
   );

   pcmctl_loader #(.MSB_FIRST(MSB_FIRST)) u_loader (
      .clk(clk_ref), .rst_n(rst_n), .hard_i(hard), .frame_hi_i(in_s[1]),
      .fall_i(fall), .bit_i(in_s[2]), .reg_a_o(reg_a), .reg_b_o(reg_b)
   );

   assign sw_req     = sleep_req(reg_a);
   assign pwrdn_o    = hard | forced | sw_req;
   assign dout_en_o  = ~pwrdn_o;
   assign sd_o       = reg_b[SD_W-1:0];
   assign test_sel_o = reg_b[REG_W-1:SD_W];
   assign gain_o     = reg_a[GAIN_W-1:0];

   // R2: a start-up or clock-loss state forces both registers on the next cycle
   a_r2_forced_regs: assert property (@(posedge clk_ref) disable iff (!rst_n)
      hard |=> (reg_a == REG_A_FORCED && reg_b == REG_B_FORCED));

   // R6: entering a register-A sleep request leaves the logic outputs as they were
   a_r6_sd_kept: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($rose(sw_req) && !$past(hard)) |-> $stable(sd_o));

endmodule

// File: tb/pcmctl_core_tb.sv
module pcmctl_core_tb;

   localparam int SYNC_STAGES = 3;
   localparam int PWRUP_EDGES = 25;
   localparam int LOSS_LIMIT  = 2500;
   localparam int FORCE_BITS  = 4;
   localparam int HP          = 8;
   localparam int N           = SYNC_STAGES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, frame_n = 1'b1, ctl_in = 1'b0, mode_neg = 1'b0;
   logic       pwrdn, dout_en;
   logic [5:0] sd, gain;
   logic [1:0] tsel;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pcmctl_core #(
      .SYNC_STAGES(SYNC_STAGES), .PWRUP_EDGES(PWRUP_EDGES),
      .REF_CLK_KHZ(125000), .LOSS_LIMIT(LOSS_LIMIT),
      .FORCE_BITS(FORCE_BITS), .MSB_FIRST(1'b1)
   ) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .bclk(bclk), .frame_n(frame_n),
      .ctl_in(ctl_in), .mode_neg(mode_neg), .pwrdn_o(pwrdn),
      .dout_en_o(dout_en), .sd_o(sd), .test_sel_o(tsel), .gain_o(gain)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // reference model: history of sampled inputs, behavioural counters
   bit qb[$], qc[$], qf[$], qm[$];
   bit smp_rst = 1'b1;
   int m_lcnt, m_pcnt, m_fcnt, m_bc, m_acc;
   bit [7:0] m_a, m_b;

   initial begin
      for (int i = 0; i < N + 2; i++) begin
         qb.push_front(0); qc.push_front(0); qf.push_front(0); qm.push_front(0);
      end
   end

   always @(posedge clk) begin
      qb.push_front(rst_n ? bclk : 1'b0);
      qc.push_front(rst_n ? ctl_in : 1'b0);
      qf.push_front(rst_n ? frame_n : 1'b0);
      qm.push_front(rst_n ? mode_neg : 1'b0);
      if (qb.size() > N + 2) begin
         void'(qb.pop_back()); void'(qc.pop_back());
         void'(qf.pop_back()); void'(qm.pop_back());
      end
      smp_rst = !rst_n;
      cyc++;
   end

   always @(negedge clk) begin
      if (smp_rst) begin
         m_lcnt = 0; m_pcnt = 0; m_fcnt = 0; m_bc = 0; m_acc = 0;
         m_a = 8'hC0; m_b = 8'h00;
      end else begin
         bit fall, d, fr, md, pw_act, loss, hard;
         int n_l;
         bit e_pd;
         fall   = qb[N+1] && !qb[N];
         d      = qc[N]; fr = qf[N]; md = qm[N];
         pw_act = (m_pcnt != PWRUP_EDGES);
         loss   = (m_lcnt == LOSS_LIMIT);
         hard   = pw_act || loss;
         n_l    = fall ? 0 : (loss ? LOSS_LIMIT : m_lcnt + 1);
         if (pw_act && fall) m_pcnt++;
         if (hard || !md) m_fcnt = 0;
         else if (fall) m_fcnt = d ? ((m_fcnt < FORCE_BITS) ? m_fcnt + 1 : FORCE_BITS) : 0;
         if (hard) begin
            m_bc = 0; m_acc = 0; m_a = 8'hC0; m_b = 8'h00;
         end else if (fr) begin
            m_bc = 0;
         end else if (fall && m_bc < 16) begin
            m_acc = ((m_acc << 1) | int'(d)) & 255;
            m_bc++;
            if (m_bc == 8)  m_a = 8'(m_acc);
            if (m_bc == 16) m_b = 8'(m_acc);
         end
         m_lcnt = n_l;
         e_pd = (m_pcnt != PWRUP_EDGES) || (m_lcnt == LOSS_LIMIT) ||
                (m_fcnt == FORCE_BITS) || (m_a[7:6] == 2'b11);
         check("R1 R3 R5 R7", "model pwrdn", int'(pwrdn), int'(e_pd));
         check("R9", "model dout_en", int'(dout_en), int'(!e_pd));
         check("R8", "model sd", int'(sd), int'(m_b[5:0]));
         check("R8", "model test_sel", int'(tsel), int'(m_b[7:6]));
         check("R10", "model gain", int'(gain), int'(m_a[5:0]));
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bit(input bit d);
      bclk = 1'b1; ctl_in = d;
      wait_cyc(HP);
      bclk = 1'b0;
      wait_cyc(HP);
   endtask

   task automatic idle(input int n, input bit d);
      frame_n = 1'b1;
      for (int i = 0; i < n; i++) send_bit(d);
   endtask

   task automatic send_frame(input bit [7:0] a, input bit [7:0] b, input int extra);
      frame_n = 1'b0;
      for (int i = 7; i >= 0; i--) send_bit(a[i]);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      for (int i = 0; i < extra; i++) send_bit(1'b1);
      frame_n = 1'b1;
      idle(1, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 100000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
         finish_run();
      end
   end

   initial begin
      wait_cyc(10);
      check("R2", "reset pwrdn", int'(pwrdn), 1);
      check("R9", "reset dout_en", int'(dout_en), 0);
      check("R2", "reset sd", int'(sd), 0);
      check("R2", "reset gain", int'(gain), 0);
      check("R2", "reset test_sel", int'(tsel), 0);
      rst_n = 1'b1;
      wait_cyc(3);

      // frame inside the start-up window is ignored
      send_frame(8'h3F, 8'h3F, 0);
      check("R1", "window gain", int'(gain), 0);
      check("R1", "window sd", int'(sd), 0);
      idle(12, 1'b0);
      check("R5", "forced sleep bits keep pwrdn", int'(pwrdn), 1);

      send_frame(8'h15, 8'h6A, 0);
      check("R10", "gain load", int'(gain), 'h15);
      check("R9", "awake dout_en", int'(dout_en), 1);
      check("R8", "sd load", int'(sd), 'h2A);
      check("R8", "transmit-filter test select", int'(tsel), 1);

      send_frame(8'h2A, 8'h95, 0);
      check("R8", "receive-filter test select", int'(tsel), 2);
      check("R8", "sd second load", int'(sd), 'h15);

      send_frame(8'h01, 8'hC0, 4);
      check("R4", "extra bits ignored gain", int'(gain), 1);
      check("R4", "extra bits ignored sd", int'(sd), 0);
      check("R8", "codec test select", int'(tsel), 3);

      frame_n = 1'b0;
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      idle(1, 1'b0);
      send_frame(8'h22, 8'h03, 0);
      check("R4", "count restart gain", int'(gain), 'h22);
      check("R4", "count restart sd", int'(sd), 3);

      send_frame(8'hC5, 8'h03, 0);
      check("R5", "sleep request pwrdn", int'(pwrdn), 1);
      check("R9", "sleep dout_en", int'(dout_en), 0);
      check("R6", "sd kept in sleep", int'(sd), 3);
      send_frame(8'hC5, 8'h2C, 0);
      check("R6", "sd updated in sleep", int'(sd), 'h2C);
      check("R6", "still asleep", int'(pwrdn), 1);

      send_frame(8'h11, 8'h00, 0);
      check("R5", "awake after clearing request", int'(pwrdn), 0);
      mode_neg = 1'b1;
      idle(2, 1'b0);
      check("R7", "no force with control low", int'(pwrdn), 0);
      idle(FORCE_BITS + 2, 1'b1);
      check("R7", "forced pwrdn", int'(pwrdn), 1);
      check("R7", "force keeps gain", int'(gain), 'h11);
      idle(1, 1'b0);
      check("R7", "control low ends force", int'(pwrdn), 0);
      mode_neg = 1'b0;

      send_frame(8'h11, 8'h05, 0);
      bclk = 1'b1;
      wait_cyc(LOSS_LIMIT + 100);
      check("R3", "clock loss pwrdn", int'(pwrdn), 1);
      check("R2", "clock loss sd", int'(sd), 0);
      check("R2", "clock loss gain", int'(gain), 0);
      check("R2", "clock loss test_sel", int'(tsel), 0);
      bclk = 1'b0;
      wait_cyc(HP);
      idle(2, 1'b0);
      check("R3", "forced request after loss", int'(pwrdn), 1);
      send_frame(8'h0A, 8'h07, 0);
      check("R3", "recovered pwrdn", int'(pwrdn), 0);
      check("R3", "recovered sd", int'(sd), 7);

      wait_cyc(20);
      finish_run();
   end

endmodule